// File: doc/BRIEF.md
# Sixteen-Pin GPIO Controller with Edge Events

This block is a general-purpose I/O peripheral for sixteen pins, driven through a small word-wide register bus. Each pin is an input or an output, chosen by its own direction bit. Output pins carry the value of a data-output register. Input pins pass through a two-flop synchronizer and are watched for edges. Each pin selects which edge it reacts to: rising, falling, both, or none.

A detected edge sets a sticky status bit for its pin. Software clears that bit by writing 1 to it. When any status bit is set and its pin is unmasked, a small request state machine raises one request line. The line it raises depends on the system mode input: in active mode it raises the synchronous interrupt, and in idle mode it raises the wake-up request.

The state machine has three states:
- `RQ_QUIET`: no request is raised.
- `RQ_INT`: the interrupt is raised.
- `RQ_WAKE`: the wake-up request is raised.

It has these transitions:
- quiet→int: a request is pending in active mode.
- quiet→wake: a request is pending in idle mode.
- int↔wake: the mode input changes while a request is pending.
- any→quiet: nothing is pending.

The data-output register and the mask register each have a set alias and a clear alias, so software can change single bits without a read-modify-write. The OR of output bits 0 to 7 drives a global output line.

Top module: `gpio_edge_unit`

## Requirements
- R1: After reset, all of the following hold: every pin is an input (`pad_oe_o`=0), `pad_out_o`=0, the mask reads 16'hFFFF (all masked), both edge registers read 0, status reads 0, and `irq_o`, `wake_o` and `glob_o` are 0.
- R2: `pad_oe_o` equals the direction register (address 0, 1 = output). `pad_out_o` equals the data-output register (address 1). A write to either register is visible in the cycle after the write.
- R3: Writing to address 2 sets each data-output bit whose written bit is 1. Writing to address 5 does the same for the mask register. Bits written as 0 are unchanged.
- R4: Writing to address 3 clears each data-output bit whose written bit is 1. Writing to address 6 does the same for the mask register. Bits written as 0 are unchanged.
- R5: A pin's edge code is {bit at address 8, bit at address 7}. Code 2'b10 or 2'b11 makes a rising edge of the synchronized input set that pin's status bit (address 9).
- R6: Code 2'b01 or 2'b11 makes a falling edge set the status bit. Code 2'b00 makes no edge set it.
- R7: A pin whose direction bit is 1 never sets its status bit, whatever its input does.
- R8: Status bits are sticky. Writing 1 clears a bit, and writing 0 leaves it unchanged.
- R9: In active mode (`idle_i`=0), `irq_o` is 1 while any status bit is set on a pin whose mask bit is 0. Masked pins never raise it.
- R10: In idle mode (`idle_i`=1), the pending request drives `wake_o` and `irq_o` stays 0. When the mode changes, the request moves to the other line.
- R11: `glob_o` is the OR of data-output bits 0 to 7. Bits 8 to 15 have no effect on it.
- R12: Address 10 reads the pin inputs after the two-flop synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, combinational on address |
| idle_i | input | 1 | System mode: 1 = idle, 0 = active |
| pad_in_i | input | 16 | Asynchronous pin inputs |
| pad_out_o | output | 16 | Pin output values |
| pad_oe_o | output | 16 | Pin output enables |
| glob_o | output | 1 | OR of output bits 0 to 7 |
| irq_o | output | 1 | Merged interrupt, active mode |
| wake_o | output | 1 | Merged wake-up request, idle mode |

## Verification
The hardest case to reach from the ports is an edge-code and edge-direction pair on one pin, such as a falling edge under code 2'b10, where the correct result is no status bit at all. Stimulus reaches it by sweeping every pin through all four codes. For each code the pin goes through one rising and one falling transition, and each transition happens only after the configuration has settled, so no spurious edge can hide a missing one. The request-steering case is reached by latching an unmasked event and then flipping `idle_i` while the event is still pending. The bench checks that the request moves between lines without being dropped.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    typedef enum logic [3:0] {
        A_DIR   = 4'd0,
        A_DOUT  = 4'd1,
        A_DSET  = 4'd2,
        A_DCLR  = 4'd3,
        A_MASK  = 4'd4,
        A_MSET  = 4'd5,
        A_MCLR  = 4'd6,
        A_EDGLO = 4'd7,
        A_EDGHI = 4'd8,
        A_STAT  = 4'd9,
        A_PIN   = 4'd10
    } reg_addr_e;

    typedef enum logic [1:0] {
        RQ_QUIET = 2'd0,
        RQ_INT   = 2'd1,
        RQ_WAKE  = 2'd2
    } req_state_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int NPIN   = 16,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] din,
    output logic [NPIN-1:0] dout
);
    logic [NPIN-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= '0;
                end else if (s == 0) begin
                    stage_q[s] <= din;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_edge.sv
module gpio_edge #(
    parameter int NPIN = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] cur,
    input  logic [NPIN-1:0] dir,
    input  logic [NPIN-1:0] edge_lo,
    input  logic [NPIN-1:0] edge_hi,
    output logic [NPIN-1:0] ev
);
    logic [NPIN-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= cur;
    end

    generate
        for (genvar i = 0; i < NPIN; i++) begin : g_pin
            logic rise, fall;
            assign rise  = cur[i] & ~prev_q[i];
            assign fall  = ~cur[i] & prev_q[i];
            assign ev[i] = ~dir[i] & ((edge_hi[i] & rise) | (edge_lo[i] & fall));
        end
    endgenerate
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int NPIN   = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NPIN-1:0]   wdata,
    input  logic [NPIN-1:0]   ev,
    input  logic [NPIN-1:0]   pin_sync,
    output logic [NPIN-1:0]   rdata,
    output logic [NPIN-1:0]   dir,
    output logic [NPIN-1:0]   dout,
    output logic [NPIN-1:0]   mask,
    output logic [NPIN-1:0]   edge_lo,
    output logic [NPIN-1:0]   edge_hi,
    output logic [NPIN-1:0]   status
);
    reg_addr_e a;
    assign a = reg_addr_e'(addr);

    logic [NPIN-1:0] stat_clr;
    assign stat_clr = (wr_en && a == A_STAT) ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir     <= '0;
            dout    <= '0;
            mask    <= '1;
            edge_lo <= '0;
            edge_hi <= '0;
            status  <= '0;
        end else begin
            if (wr_en) begin
                unique case (a)
                    A_DIR:   dir     <= wdata;
                    A_DOUT:  dout    <= wdata;
                    A_DSET:  dout    <= dout | wdata;
                    A_DCLR:  dout    <= dout & ~wdata;
                    A_MASK:  mask    <= wdata;
                    A_MSET:  mask    <= mask | wdata;
                    A_MCLR:  mask    <= mask & ~wdata;
                    A_EDGLO: edge_lo <= wdata;
                    A_EDGHI: edge_hi <= wdata;
                    default: ;
                endcase
            end
            status <= (status & ~stat_clr) | ev;
        end
    end

    always_comb begin
        unique case (a)
            A_DIR:                  rdata = dir;
            A_DOUT, A_DSET, A_DCLR: rdata = dout;
            A_MASK, A_MSET, A_MCLR: rdata = mask;
            A_EDGLO:                rdata = edge_lo;
            A_EDGHI:                rdata = edge_hi;
            A_STAT:                 rdata = status;
            A_PIN:                  rdata = pin_sync;
            default:                rdata = '0;
        endcase
    end

    // R3: set alias ORs the written bits into the data-output register
    p_dset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && a == A_DSET) |=> dout == ($past(dout) | $past(wdata)));

    // R4: clear alias removes the written bits from the mask register
    p_mclr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && a == A_MCLR) |=> mask == ($past(mask) & ~$past(wdata)));

    // R8: without a status write, no set status bit is lost
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && a == A_STAT) |=> (status & $past(status)) == $past(status));

    // R7: newly set status bits only on pins that were inputs
    p_outpin_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (status & ~$past(status) & $past(dir)) == '0);
endmodule

// File: rtl/gpio_req_fsm.sv
module gpio_req_fsm
    import gpio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending_i,
    input  logic idle_i,
    output logic irq_o,
    output logic wake_o
);
    req_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RQ_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RQ_QUIET: if (pending_i) state_d = idle_i ? RQ_WAKE : RQ_INT;
            RQ_INT: begin
                if (!pending_i)  state_d = RQ_QUIET;
                else if (idle_i) state_d = RQ_WAKE;
            end
            RQ_WAKE: begin
                if (!pending_i)   state_d = RQ_QUIET;
                else if (!idle_i) state_d = RQ_INT;
            end
            default: state_d = RQ_QUIET;
        endcase
    end

    always_comb begin
        irq_o  = 1'b0;
        wake_o = 1'b0;
        unique case (state_q)
            RQ_INT:  irq_o  = 1'b1;
            RQ_WAKE: wake_o = 1'b1;
            default: ;
        endcase
    end

    // R9: interrupt only after an active-mode cycle with a pending request
    p_irq_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ($past(!idle_i) && $past(pending_i)));

    // R10: wake-up only after an idle-mode cycle with a pending request
    p_wake_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> ($past(idle_i) && $past(pending_i)));

    // R10: mode switch with request still pending moves it to the other line
    p_move_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && idle_i && pending_i) |=> wake_o);
endmodule

// File: rtl/gpio_edge_unit.sv
module gpio_edge_unit #(
    parameter int NPIN      = 16,
    parameter int ADDR_W    = 4,
    parameter int GLOB_BITS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [NPIN-1:0]   bus_wdata_i,
    output logic [NPIN-1:0]   bus_rdata_o,
    input  logic              idle_i,
    input  logic [NPIN-1:0]   pad_in_i,
    output logic [NPIN-1:0]   pad_out_o,
    output logic [NPIN-1:0]   pad_oe_o,
    output logic              glob_o,
    output logic              irq_o,
    output logic              wake_o
);
    logic [NPIN-1:0] pin_s, ev, dir, dout, mask, edge_lo, edge_hi, status;
    logic            pending;

    gpio_sync #(.NPIN(NPIN), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(pad_in_i), .dout(pin_s)
    );

    gpio_edge #(.NPIN(NPIN)) u_edge (
        .clk(clk), .rst_n(rst_n), .cur(pin_s), .dir(dir),
        .edge_lo(edge_lo), .edge_hi(edge_hi), .ev(ev)
    );

    gpio_regs #(.NPIN(NPIN), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_i), .addr(bus_addr_i),
        .wdata(bus_wdata_i), .ev(ev), .pin_sync(pin_s), .rdata(bus_rdata_o),
        .dir(dir), .dout(dout), .mask(mask), .edge_lo(edge_lo),
        .edge_hi(edge_hi), .status(status)
    );

    assign pending = |(status & ~mask);

    gpio_req_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .pending_i(pending), .idle_i(idle_i),
        .irq_o(irq_o), .wake_o(wake_o)
    );

    assign pad_out_o = dout;
    assign pad_oe_o  = dir;
    assign glob_o    = |dout[GLOB_BITS-1:0];
endmodule

// File: tb/gpio_edge_unit_tb.sv
module gpio_edge_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        idle = 1'b0;
    logic [15:0] pad_in = '0;
    logic [15:0] pad_out, pad_oe;
    logic        glob, irq, wake;

    int nvec = 0;
    int nbad = 0;

    always #10 clk = ~clk;

    gpio_edge_unit dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .idle_i(idle),
        .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe),
        .glob_o(glob), .irq_o(irq), .wake_o(wake)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        nvec++;
        if (got !== exp) begin
            nbad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        #3_000_000;
        nbad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        logic [15:0] v;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);

        // R1: reset state
        check("R1 oe", pad_oe, 16'h0);
        check("R1 out", pad_out, 16'h0);
        check("R1 req", {13'd0, glob, irq, wake}, 16'h0);
        rd(4, v); check("R1 mask", v, 16'hFFFF);
        rd(7, v); check("R1 edglo", v, 16'h0);
        rd(8, v); check("R1 edghi", v, 16'h0);
        rd(9, v); check("R1 stat", v, 16'h0);

        // R2: direction and data drive the pins
        wr(0, 16'h5A3C); check("R2 oe", pad_oe, 16'h5A3C);
        wr(1, 16'hC0DE); check("R2 out", pad_out, 16'hC0DE);
        wr(0, 16'h0000);

        // R3 and R4: set/clear aliases on data-output and mask
        wr(1, 16'h00F0);
        wr(2, 16'h0103); check("R3 dset", pad_out, 16'h01F3);
        wr(3, 16'h0031); check("R4 dclr", pad_out, 16'h01C2);
        wr(4, 16'h0000);
        wr(5, 16'h8001); rd(4, v); check("R3 mset", v, 16'h8001);
        wr(6, 16'h0001); rd(4, v); check("R4 mclr", v, 16'h8000);
        wr(4, 16'hFFFF);

        // R11: global line sweep over the low byte with varying high bits
        for (int b = 0; b < 256; b++) begin
            wr(1, {8'(b * 37), 8'(b)});
            check("R11 glob", {15'd0, glob}, {15'd0, (b != 0)});
        end
        wr(1, 16'h0000);

        // R12: synchronized pin readback
        pad_in = 16'hA5C3;
        wait_cyc(3);
        rd(10, v); check("R12 pins", v, 16'hA5C3);
        pad_in = 16'h0000;
        wait_cyc(4);
        wr(9, 16'hFFFF);

        // R5 and R6: every pin through every edge code, both edge directions
        for (int p = 0; p < 16; p++) begin
            for (int e = 0; e < 4; e++) begin
                wr(7, (e[0]) ? (16'h1 << p) : 16'h0);
                wr(8, (e[1]) ? (16'h1 << p) : 16'h0);
                wr(9, 16'hFFFF);
                pad_in = 16'h1 << p;
                wait_cyc(4);
                rd(9, v);
                check("R5 rise", v, (e >= 2) ? (16'h1 << p) : 16'h0);
                wr(9, 16'hFFFF);
                pad_in = 16'h0;
                wait_cyc(4);
                rd(9, v);
                check("R6 fall", v, (e == 1 || e == 3) ? (16'h1 << p) : 16'h0);
                wr(9, 16'hFFFF);
            end
        end
        check("R9 masked sweep irq", {15'd0, irq}, 16'h0);

        // R7: output pins never latch events
        wr(7, 16'hFFFF); wr(8, 16'hFFFF);
        wr(0, 16'h0F00);
        pad_in = 16'h0F00; wait_cyc(4);
        pad_in = 16'h0000; wait_cyc(4);
        rd(9, v); check("R7 outpins", v, 16'h0000);
        wr(0, 16'h0000);

        // R8: sticky and write-1-to-clear
        pad_in = 16'h0012; wait_cyc(4);
        rd(9, v); check("R8 set", v, 16'h0012);
        wr(9, 16'h0000); rd(9, v); check("R8 zero write", v, 16'h0012);
        wr(9, 16'h0002); rd(9, v); check("R8 w1c", v, 16'h0010);
        wr(9, 16'hFFFF);
        pad_in = 16'h0000; wait_cyc(4);
        wr(9, 16'hFFFF);

        // R9: masked event raises nothing, unmasked raises irq
        pad_in = 16'h0008; wait_cyc(6);
        check("R9 masked", {14'd0, irq, wake}, 16'h0);
        wr(6, 16'h0008); wait_cyc(2);
        check("R9 irq", {14'd0, irq, wake}, 16'h0002);

        // R10: move to idle, then back, then clear
        idle = 1'b1; wait_cyc(2);
        check("R10 wake", {14'd0, irq, wake}, 16'h0001);
        idle = 1'b0; wait_cyc(2);
        check("R10 back", {14'd0, irq, wake}, 16'h0002);
        wr(9, 16'hFFFF); wait_cyc(2);
        check("R9 clear", {14'd0, irq, wake}, 16'h0);
        idle = 1'b1;
        pad_in = 16'h0000; wait_cyc(6);
        check("R10 idle event", {14'd0, irq, wake}, 16'h0001);
        wr(9, 16'hFFFF); wait_cyc(2);
        check("R10 clear", {14'd0, irq, wake}, 16'h0);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule